// File: doc/BRIEF.md
# Multi-Lane Constant-Set Twiddle Rotator

This block rotates several complex samples at once by 64th roots of unity. Each lane takes a signed complex sample and a 6-bit exponent p, and delivers the sample multiplied by exp(-j*2*pi*p/64). There are no general multipliers. A small bank of fixed-coefficient units builds each product from shifted copies of the sample. Every exponent is folded onto one of nine base angles between 0 and 45 degrees. The angle is then restored by swapping cosine and sine and by a quarter-turn rotation. The quarter-turn rotation only swaps the real and imaginary parts and negates them.

Each base angle from 1 to 8 has one shared coefficient unit. The lane that asks for that angle in a cycle is routed to it. Base angle 0 is unity, so it uses no unit at all. Base angle 4 is the one that two lanes most often request together, so it has a second, duplicate unit. The scheduler upstream must keep to this sharing limit. The result is registered, so it appears one cycle after the input. A valid flag travels with the data.

Top module: `twiddle_rotator`

## Requirements
- R1: For each lane and every p in 0..63, the output is x*(cos(2*pi*p/64) - j*sin(2*pi*p/64)), within 8 LSB. The coefficients carry 12 fractional bits. Each part is cut back to DATA_W bits by an arithmetic right shift (rounding toward minus infinity).
- R2: A beat presented with inValid high appears on the outputs exactly one clock edge later, with outValid high. Back-to-back beats are accepted on every cycle.
- R3: When p[3:0] is 0, the result is exact: p=0 gives (re, im), p=16 gives (im, -re), p=32 gives (-re, -im), p=48 gives (-im, re).
- R4: When p[3] is 1, the base angle is 8 - p[2:0] and the roles of cosine and sine are swapped. This covers the 45-degree points p = 8, 24, 40, 56.
- R5: p[5:4] selects a quarter-turn of (-j)^p[5:4], applied after the base-angle product.
- R6: Two lanes whose base angle is 4 (p[2:0] = 4) in the same cycle are both rotated correctly.
- R7: In a valid cycle, each base angle 1..8 other than 4 may be used by at most one lane, and base angle 4 by at most two lanes. Base angle 0 may be used by any number of lanes.
- R8: During reset, outValid and all outputs are 0. While inValid is low, outValid is 0 and the outputs keep their last values whatever the other inputs do.
- R9: Lanes are independent. Lane l uses bits [l*DATA_W +: DATA_W] of the data buses and bits [l*6 +: 6] of inExp.

Top module parameters: DATA_W (sample width, default 16) and LANES (default 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input beat is valid |
| inRe | input | LANES*DATA_W | Real parts of the input samples, signed, lane-packed |
| inIm | input | LANES*DATA_W | Imaginary parts of the input samples, signed, lane-packed |
| inExp | input | LANES*6 | Twiddle exponent p for each lane |
| outValid | output | 1 | Output beat is valid |
| outRe | output | LANES*DATA_W | Real parts of the rotated samples |
| outIm | output | LANES*DATA_W | Imaginary parts of the rotated samples |

## Verification
The bench sweeps all 64 exponents on each lane in turn, while the other lanes run quarter-turn exponents in the same beats. A wrong octant fold or a missing cosine/sine swap would then give errors of thousands of LSB near the octant edges, not a few.

The multiples of 16 are held to an exact match. A trivial path that leaked through a quantised coefficient, or a quarter-turn with a wrong sign, would miss it by one LSB or by the whole sample.

Beats in which two lanes share base angle 4 catch a design whose duplicate unit is missing or misrouted. In such a design the second lane would receive the first lane's product.

A gap check with changing inputs shows whether the outputs hold or drift while no beat is valid.

// File: rtl/twiddle_pkg.sv
`timescale 1ns/1ps
package twiddle_pkg;
  localparam int FRAC_BITS   = 12;
  localparam int COEF_W      = FRAC_BITS + 1;
  localparam int EXP_W       = 6;
  localparam int NUM_UNITS   = 10;   // index 0 is the unity path, 9 is the duplicate
  localparam int SHARED_BASE = 4;
  localparam int DUP_UNIT    = 9;
  localparam int QUARTER     = 16;   // exponent steps per quarter turn

  typedef logic [3:0] unitIdx_t;

  typedef struct packed {
    unitIdx_t   unitIdx;  // 0: unity, 1..8: base angle unit, 9: second base-4 unit
    logic       swap;     // use sine where cosine would be used and vice versa
    logic [1:0] quad;     // number of -j quarter turns
  } laneCtl_t;

  // cos(2*pi*k/64) scaled by 2^FRAC_BITS and rounded, k in 0..16
  function automatic logic [COEF_W-1:0] cosCoef(input int k);
    case (k)
      0:  return 13'd4096;
      1:  return 13'd4076;
      2:  return 13'd4017;
      3:  return 13'd3920;
      4:  return 13'd3784;
      5:  return 13'd3612;
      6:  return 13'd3406;
      7:  return 13'd3166;
      8:  return 13'd2896;
      9:  return 13'd2598;
      10: return 13'd2276;
      11: return 13'd1931;
      12: return 13'd1567;
      13: return 13'd1189;
      14: return 13'd799;
      15: return 13'd401;
      default: return 13'd0;
    endcase
  endfunction
endpackage

// File: rtl/twiddle_const_unit.sv
`timescale 1ns/1ps
module twiddle_const_unit
  import twiddle_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BASE   = 1,
  localparam int PROD_W = DATA_W + COEF_W
) (
  input  logic signed [DATA_W-1:0] xRe,
  input  logic signed [DATA_W-1:0] xIm,
  output logic signed [PROD_W-1:0] reCos,
  output logic signed [PROD_W-1:0] imCos,
  output logic signed [PROD_W-1:0] reSin,
  output logic signed [PROD_W-1:0] imSin
);
  localparam logic [COEF_W-1:0] COS_K = cosCoef(BASE);
  localparam logic [COEF_W-1:0] SIN_K = cosCoef(QUARTER - BASE);

  // fixed coefficient: sum of shifted copies, only where the coefficient has a one
  function automatic logic signed [PROD_W-1:0] shiftAdd(input logic signed [DATA_W-1:0] x,
                                                        input logic [COEF_W-1:0] c);
    logic signed [PROD_W-1:0] acc;
    logic signed [PROD_W-1:0] ext;
    acc = '0;
    ext = PROD_W'(x);
    for (int i = 0; i < COEF_W; i++) begin
      if (c[i]) acc = acc + (ext <<< i);
    end
    return acc;
  endfunction

  assign reCos = shiftAdd(xRe, COS_K);
  assign imCos = shiftAdd(xIm, COS_K);
  assign reSin = shiftAdd(xRe, SIN_K);
  assign imSin = shiftAdd(xIm, SIN_K);
endmodule

// File: rtl/twiddle_ctrl.sv
`timescale 1ns/1ps
module twiddle_ctrl
  import twiddle_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  input  logic [LANES*EXP_W-1:0] inExp,
  output logic                   load,
  output laneCtl_t               laneCtl [LANES]
);
  unitIdx_t baseIdx [LANES];

  assign load = inValid;

  always_comb begin
    logic taken;
    taken = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      logic [EXP_W-1:0] pv;
      pv = inExp[l*EXP_W +: EXP_W];
      // odd octant mirrors onto 8 - r; p[3]=1 with r=0 lands on 8
      baseIdx[l]      = pv[3] ? (4'd8 - {1'b0, pv[2:0]}) : {1'b0, pv[2:0]};
      laneCtl[l].swap = pv[3];
      laneCtl[l].quad = pv[5:4];
      if (baseIdx[l] == unitIdx_t'(SHARED_BASE) && taken) begin
        laneCtl[l].unitIdx = unitIdx_t'(DUP_UNIT);
      end else begin
        laneCtl[l].unitIdx = baseIdx[l];
        if (baseIdx[l] == unitIdx_t'(SHARED_BASE)) taken = 1'b1;
      end
    end
  end

  // sharing limit on each coefficient unit (R7)
  for (genvar k = 1; k <= 8; k++) begin : g_share
    logic [LANES-1:0] hit;
    always_comb begin
      for (int l = 0; l < LANES; l++) hit[l] = (baseIdx[l] == unitIdx_t'(k));
    end
    p_share_limit_r7: assert property (@(posedge clk) disable iff (!rstN)
      inValid |-> ($countones(hit) <= ((k == SHARED_BASE) ? 2 : 1)));
  end
endmodule

// File: rtl/twiddle_datapath.sv
`timescale 1ns/1ps
module twiddle_datapath
  import twiddle_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LANES  = 4,
  localparam int PROD_W = DATA_W + COEF_W,
  localparam int SUM_W  = PROD_W + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    load,
  input  laneCtl_t                laneCtl [LANES],
  input  logic [LANES*DATA_W-1:0] inRe,
  input  logic [LANES*DATA_W-1:0] inIm,
  output logic                    outValid,
  output logic [LANES*DATA_W-1:0] outRe,
  output logic [LANES*DATA_W-1:0] outIm
);
  logic signed [DATA_W-1:0] xRe [LANES];
  logic signed [DATA_W-1:0] xIm [LANES];
  logic signed [DATA_W-1:0] rotRe [LANES];
  logic signed [DATA_W-1:0] rotIm [LANES];

  logic signed [DATA_W-1:0] unitRe [1:NUM_UNITS-1];
  logic signed [DATA_W-1:0] unitIm [1:NUM_UNITS-1];
  logic signed [PROD_W-1:0] prodRC [1:NUM_UNITS-1];
  logic signed [PROD_W-1:0] prodIC [1:NUM_UNITS-1];
  logic signed [PROD_W-1:0] prodRS [1:NUM_UNITS-1];
  logic signed [PROD_W-1:0] prodIS [1:NUM_UNITS-1];

  for (genvar l = 0; l < LANES; l++) begin : g_unpack
    assign xRe[l] = inRe[l*DATA_W +: DATA_W];
    assign xIm[l] = inIm[l*DATA_W +: DATA_W];
  end

  // route each lane to the coefficient unit it was granted
  always_comb begin
    for (int u = 1; u < NUM_UNITS; u++) begin
      unitRe[u] = '0;
      unitIm[u] = '0;
      for (int l = 0; l < LANES; l++) begin
        if (laneCtl[l].unitIdx == unitIdx_t'(u)) begin
          unitRe[u] = xRe[l];
          unitIm[u] = xIm[l];
        end
      end
    end
  end

  for (genvar g = 1; g < NUM_UNITS; g++) begin : g_unit
    twiddle_const_unit #(
      .DATA_W(DATA_W),
      .BASE  ((g == DUP_UNIT) ? SHARED_BASE : g)
    ) uConst (
      .xRe  (unitRe[g]),
      .xIm  (unitIm[g]),
      .reCos(prodRC[g]),
      .imCos(prodIC[g]),
      .reSin(prodRS[g]),
      .imSin(prodIS[g])
    );
  end

  function automatic logic signed [DATA_W-1:0] scaleSum(input logic signed [PROD_W-1:0] a,
                                                        input logic signed [PROD_W-1:0] b,
                                                        input logic subtract);
    if (subtract) return DATA_W'((SUM_W'(a) - SUM_W'(b)) >>> FRAC_BITS);
    else          return DATA_W'((SUM_W'(a) + SUM_W'(b)) >>> FRAC_BITS);
  endfunction

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      logic signed [PROD_W-1:0] rc, ic, rs, is;
      logic signed [DATA_W-1:0] baseRe, baseIm;
      if (laneCtl[l].unitIdx == '0) begin
        rc = PROD_W'(xRe[l]) <<< FRAC_BITS;
        ic = PROD_W'(xIm[l]) <<< FRAC_BITS;
        rs = '0;
        is = '0;
      end else begin
        rc = prodRC[laneCtl[l].unitIdx];
        ic = prodIC[laneCtl[l].unitIdx];
        rs = prodRS[laneCtl[l].unitIdx];
        is = prodIS[laneCtl[l].unitIdx];
      end
      if (laneCtl[l].swap) begin
        baseRe = scaleSum(rs, ic, 1'b0);
        baseIm = scaleSum(is, rc, 1'b1);
      end else begin
        baseRe = scaleSum(rc, is, 1'b0);
        baseIm = scaleSum(ic, rs, 1'b1);
      end
      case (laneCtl[l].quad)
        2'd0: begin rotRe[l] = baseRe;  rotIm[l] = baseIm;  end
        2'd1: begin rotRe[l] = baseIm;  rotIm[l] = -baseRe; end
        2'd2: begin rotRe[l] = -baseRe; rotIm[l] = -baseIm; end
        default: begin rotRe[l] = -baseIm; rotIm[l] = baseRe; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outRe    <= '0;
      outIm    <= '0;
    end else begin
      outValid <= load;
      if (load) begin
        for (int l = 0; l < LANES; l++) begin
          outRe[l*DATA_W +: DATA_W] <= rotRe[l];
          outIm[l*DATA_W +: DATA_W] <= rotIm[l];
        end
      end
    end
  end

  p_hold_re_r8: assert property (@(posedge clk) disable iff (!rstN)
    !load |=> ($stable(outRe) && $stable(outIm) && !outValid));
endmodule

// File: rtl/twiddle_rotator.sv
`timescale 1ns/1ps
module twiddle_rotator
  import twiddle_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [LANES*DATA_W-1:0] inRe,
  input  logic [LANES*DATA_W-1:0] inIm,
  input  logic [LANES*EXP_W-1:0]  inExp,
  output logic                    outValid,
  output logic [LANES*DATA_W-1:0] outRe,
  output logic [LANES*DATA_W-1:0] outIm
);
  logic     load;
  laneCtl_t laneCtl [LANES];

  twiddle_ctrl #(.LANES(LANES)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .inExp  (inExp),
    .load   (load),
    .laneCtl(laneCtl)
  );

  twiddle_datapath #(.DATA_W(DATA_W), .LANES(LANES)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .load    (load),
    .laneCtl (laneCtl),
    .inRe    (inRe),
    .inIm    (inIm),
    .outValid(outValid),
    .outRe   (outRe),
    .outIm   (outIm)
  );

  p_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // unity exponent passes the sample through unchanged (R3)
  for (genvar l = 0; l < LANES; l++) begin : g_pass
    p_unity_exact_r3: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && inExp[l*EXP_W +: EXP_W] == '0) |=>
        (outRe[l*DATA_W +: DATA_W] == $past(inRe[l*DATA_W +: DATA_W]) &&
         outIm[l*DATA_W +: DATA_W] == $past(inIm[l*DATA_W +: DATA_W])));
  end
endmodule

// File: tb/tb_twiddle_rotator.sv
`timescale 1ns/1ps
module tb_twiddle_rotator;
  localparam int DW = 16;
  localparam int NL = 4;
  localparam real PI = 3.14159265358979;
  localparam real TOL = 8.0;
  localparam real EXACT_TOL = 0.001;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [NL*DW-1:0] inRe = '0;
  logic [NL*DW-1:0] inIm = '0;
  logic [NL*6-1:0]  inExp = '0;
  logic outValid;
  logic [NL*DW-1:0] outRe;
  logic [NL*DW-1:0] outIm;

  int nChecks = 0;
  int nFails = 0;
  bit monOn = 1'b0;

  real expRe [$];
  real expIm [$];
  real expTol [$];
  string expTag [$];

  int pLane [NL];
  int reLane [NL];
  int imLane [NL];

  twiddle_rotator #(.DATA_W(DW), .LANES(NL)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .inRe(inRe), .inIm(inIm), .inExp(inExp),
    .outValid(outValid), .outRe(outRe), .outIm(outIm)
  );

  always #2 clk = ~clk;

  function automatic int smp(input logic [NL*DW-1:0] bus, input int l);
    logic signed [DW-1:0] v;
    v = bus[l*DW +: DW];
    return int'(v);
  endfunction

  task automatic checkVal(input string tag, input string what, input int act,
                          input real exp, input real tol);
    real d;
    nChecks++;
    d = real'(act) - exp;
    if (d < 0.0) d = -d;
    if (d > tol) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %f", tag, what, act, exp);
    end
  endtask

  // driver: present one beat and queue the expected result per lane
  task automatic sendBeat(input string tag, input bit exact);
    for (int l = 0; l < NL; l++) begin
      real th, c, s;
      th = 2.0 * PI * real'(pLane[l]) / 64.0;
      c = $cos(th);
      s = $sin(th);
      inRe[l*DW +: DW] = DW'(reLane[l]);
      inIm[l*DW +: DW] = DW'(imLane[l]);
      inExp[l*6 +: 6]  = 6'(pLane[l]);
      expRe.push_back(real'(reLane[l]) * c + real'(imLane[l]) * s);
      expIm.push_back(real'(imLane[l]) * c - real'(reLane[l]) * s);
      expTol.push_back((exact || (pLane[l] % 16 == 0)) ? EXACT_TOL : TOL);
      expTag.push_back(tag);
    end
    inValid = 1'b1;
    @(negedge clk);
  endtask

  function automatic int rnd();
    return int'($urandom_range(40000)) - 20000;
  endfunction

  // monitor: pop and compare whenever a result is presented
  always @(negedge clk) begin
    if (monOn && outValid) begin
      for (int l = 0; l < NL; l++) begin
        if (expRe.size() == 0) begin
          nChecks++;
          nFails++;
          $display("FAIL R2 unexpected output beat lane %0d: actual valid 1 expected 0", l);
        end else begin
          real er, ei, tl;
          string tg;
          er = expRe.pop_front();
          ei = expIm.pop_front();
          tl = expTol.pop_front();
          tg = expTag.pop_front();
          checkVal(tg, $sformatf("lane %0d re", l), smp(outRe, l), er, tl);
          checkVal(tg, $sformatf("lane %0d im", l), smp(outIm, l), ei, tl);
        end
      end
    end
  end

  initial begin
    #400000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks + 1, nFails);
    $finish;
  end

  initial begin
    int heldRe, heldIm;
    repeat (3) @(negedge clk);
    // R8: reset state
    checkVal("R8", "reset outValid", int'(outValid), 0.0, 0.0);
    checkVal("R8", "reset outRe lane 0", smp(outRe, 0), 0.0, 0.0);
    checkVal("R8", "reset outIm lane 3", smp(outIm, 3), 0.0, 0.0);
    rstN = 1'b1;
    @(negedge clk);
    monOn = 1'b1;

    // R2: single beat, result appears one edge later, then valid drops
    for (int l = 0; l < NL; l++) begin
      pLane[l] = 16 * l;
      reLane[l] = 1000 + l;
      imLane[l] = -2000 - l;
    end
    checkVal("R2", "valid before beat", int'(outValid), 0.0, 0.0);
    sendBeat("R2", 1'b1);
    inValid = 1'b0;
    // outValid checked by the monitor at this edge; latency check explicit too
    checkVal("R2", "valid one edge after beat", int'(outValid), 1.0, 0.0);
    heldRe = smp(outRe, 1);
    heldIm = smp(outIm, 2);
    inRe = {NL{16'h1234}};
    inIm = {NL{16'h4321}};
    inExp = {NL{6'd5}};
    @(negedge clk);
    checkVal("R2", "valid drops after single beat", int'(outValid), 0.0, 0.0);
    // R8: outputs hold while idle with changing inputs
    inRe = {NL{16'h0777}};
    @(negedge clk);
    checkVal("R8", "hold re lane 1", smp(outRe, 1), real'(heldRe), 0.0);
    checkVal("R8", "hold im lane 2", smp(outIm, 2), real'(heldIm), 0.0);
    checkVal("R8", "idle outValid", int'(outValid), 0.0, 0.0);

    // R3: exact quarter turns with extreme values
    pLane = '{0, 16, 32, 48};
    reLane = '{20000, -20000, 32767, -32767};
    imLane = '{-20000, 20000, -32767, 32767};
    sendBeat("R3", 1'b1);
    pLane = '{48, 32, 16, 0};
    reLane = '{123, -1, 0, 32767};
    imLane = '{-456, 1, -32767, -5};
    sendBeat("R3", 1'b1);

    // R1 R4 R5 R9: sweep every exponent on each lane, others on quarter turns
    for (int L = 0; L < NL; L++) begin
      for (int p = 0; p < 64; p++) begin
        string tg;
        for (int o = 0; o < NL; o++) begin
          pLane[o] = (o == L) ? p : 16 * ((p + o) % 4);
          reLane[o] = rnd();
          imLane[o] = rnd();
        end
        if (p % 16 == 0) tg = "R3";
        else if (p % 16 >= 8) tg = "R4";
        else if (p >= 16) tg = "R5";
        else tg = (L == 0) ? "R1" : "R9";
        sendBeat(tg, 1'b0);
        if (p % 13 == 12) begin
          inValid = 1'b0;
          @(negedge clk);
        end
      end
    end

    // R6: two lanes on base angle 4 in one beat, in several lane positions
    pLane = '{4, 28, 1, 50};
    for (int l = 0; l < NL; l++) begin reLane[l] = rnd(); imLane[l] = rnd(); end
    sendBeat("R6", 1'b0);
    pLane = '{20, 9, 34, 60};
    reLane = '{20000, -20000, 20000, -20000};
    imLane = '{20000, -20000, 0, 20000};
    sendBeat("R6", 1'b0);
    pLane = '{3, 0, 36, 12};
    for (int l = 0; l < NL; l++) begin reLane[l] = rnd(); imLane[l] = rnd(); end
    sendBeat("R6", 1'b0);
    pLane = '{8, 0, 52, 44};
    reLane = '{14142, 7, -9999, 18000};
    imLane = '{14142, -7, 4321, -18000};
    sendBeat("R6", 1'b0);

    inValid = 1'b0;
    repeat (3) @(negedge clk);
    checkVal("R2", "all queued beats delivered", expRe.size(), 0.0, 0.0);
    checkVal("R8", "final idle outValid", int'(outValid), 0.0, 0.0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule